// File: doc/BRIEF.md
# Two-Wire Serial Slave for a Digital Potentiometer

This block connects a digital potentiometer to a two-wire serial bus (I2C-compatible) as a slave. It samples the clock and data lines with its own system clock. It detects start and stop conditions and matches its 7-bit bus address. The two low bits of that address come from strap inputs, so four such devices can share one bus. The data line is never driven high. The block only pulls it low, through an active-low drive enable.

A write carries an instruction byte after the address byte. When the top bit of the instruction is clear, the data byte that follows is written either to one of four 8-bit wiper registers or to one of sixteen 8-bit registers that model a nonvolatile store. Bit 5 of the instruction chooses between the two arrays. When the top bit is set, the instruction is a command. It is not executed here. It is decoded and reported on a one-cycle strobe, with its code and the wiper it targets. A read needs no instruction byte and keeps no register pointer: it always starts at wiper 0 and steps through the wipers for as long as the master acknowledges.

Top module: `potctl_i2c_slave`

## Requirements
- R1: The slave acknowledges, by pulling the data line low during the ninth clock pulse, an address byte whose upper seven bits equal 01011 followed by `strap_addr[1:0]`. Bit 0 of that byte selects a read (1) or a write (0).
- R2: After an address byte that does not match, the slave neither acknowledges nor drives the data line, and it ignores every later byte until the next start condition.
- R3: A start condition (data falling while the clock is high) restarts address reception at any point, including in the middle of a byte or without a preceding stop. A stop condition (data rising while the clock is high) returns the slave to idle with the data line released.
- R4: In a write, an instruction byte with bit 7 = 0 and bit 5 = 0 addresses wiper register `instr[4:0]` (0..3). The following data byte is acknowledged and stored there, and it appears on `wiper_q[8*i +: 8]`.
- R5: An instruction byte with bit 7 = 0 and bit 5 = 1 addresses nonvolatile-model register `instr[4:0]` (0..15). The following data byte is acknowledged and stored there, and it appears on `nvm_q[8*i +: 8]`.
- R6: Writes to wiper addresses 4..31, or to nonvolatile addresses 16..31, are acknowledged and discarded: no register changes.
- R7: An instruction byte with bit 7 = 1 is a command with code `instr[6:3]` and wiper select `instr[2:0]`. For select 001 or 011 the slave acknowledges and raises `cmd_strobe` for exactly one cycle, with `cmd_code` = code and `cmd_wiper` = `instr[1:0]`.
- R8: A command whose wiper select is not 001 or 011 is acknowledged but raises no strobe. Bytes after a command, or after a completed register write, are acknowledged and have no effect.
- R9: In a read, the slave sends wiper 0 most significant bit first, starting right after its address acknowledge. Each master acknowledge advances to the next wiper, and the index wraps from 3 back to 0.
- R10: A master no-acknowledge ends the read and releases the data line. The next read starts again at wiper 0.
- R11: After reset every wiper holds 0x80, every nonvolatile-model register holds 0x00, the data line is released and `cmd_strobe` is low.
- R12: The drive enable changes only while the synchronised clock is low, except for the release forced by a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 leaves it released |
| strap_addr | input | 2 | Strap inputs giving the two low address bits |
| cmd_strobe | output | 1 | One-cycle pulse for a valid command |
| cmd_code | output | 4 | Command code reported with the strobe |
| cmd_wiper | output | 2 | Wiper index reported with the strobe (1 or 3) |
| wiper_q | output | 32 | Four wiper registers, wiper i at bits 8i+7..8i |
| nvm_q | output | 128 | Sixteen nonvolatile-model registers, register i at bits 8i+7..8i |

## Verification
The checks on the drive enable assume that the master behaves like a legal bus master. It changes the data line only while the clock is low, except when it means a start or stop. It also holds every clock phase for several system clocks, so the synchroniser sees each level. The bench master keeps each quarter bit time to eight system clocks and moves its data line only in the clock-low quarters. The single exceptions are its deliberate start and stop conditions. The bus line is modelled as the wired AND of the master's output and the slave's pull-down, so acknowledges and read data are observed exactly as a real master would see them.

// File: rtl/potctl_pkg.sv
package potctl_pkg;

    localparam int DATA_W   = 8;
    localparam int REG_AW   = 5;
    localparam int N_WIPER  = 4;
    localparam int N_NVM    = 16;
    localparam int CODE_W   = 4;
    localparam int BITCNT_W = 4;
    localparam logic [4:0] DEV_ID_HI = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INSTR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } phase_t;

    typedef struct packed {
        logic              is_cmd;
        logic [CODE_W-1:0] code;
        logic [2:0]        sel;
    } cmd_view_t;

    typedef struct packed {
        logic              is_cmd;
        logic              spare;
        logic              to_nvm;
        logic [REG_AW-1:0] addr;
    } reg_view_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [1:0] strap);
        return b[7:1] == {DEV_ID_HI, strap};
    endfunction

    function automatic logic sel_valid(input logic [2:0] sel);
        return (sel == 3'b001) || (sel == 3'b011);
    endfunction

endpackage

// File: rtl/potctl_line_sync.sv
module potctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/potctl_bit_shift.sv
module potctl_bit_shift
    import potctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                rise,
    input  logic                sda,
    output logic [BITCNT_W-1:0] bitcnt,
    output logic [DATA_W-1:0]   rx_byte,
    output logic                byte_rx,
    output logic                ack_slot,
    output logic                ack_bit
);
    localparam logic [BITCNT_W-1:0] ACK_POS = BITCNT_W'(DATA_W);
    localparam logic [BITCNT_W-1:0] LAST_DB = BITCNT_W'(DATA_W - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bitcnt   <= '0;
            rx_byte  <= '0;
            byte_rx  <= 1'b0;
            ack_slot <= 1'b0;
            ack_bit  <= 1'b1;
        end else begin
            byte_rx  <= 1'b0;
            ack_slot <= 1'b0;
            if (rise) begin
                if (bitcnt == ACK_POS) begin
                    bitcnt   <= '0;
                    ack_slot <= 1'b1;
                    ack_bit  <= sda;
                end else begin
                    rx_byte <= {rx_byte[DATA_W-2:0], sda};
                    bitcnt  <= bitcnt + 1'b1;
                    byte_rx <= (bitcnt == LAST_DB);
                end
            end
        end
    end

endmodule

// File: rtl/potctl_regbank.sv
module potctl_regbank
    import potctl_pkg::*;
#(
    parameter int NW = N_WIPER,
    parameter int NN = N_NVM,
    parameter logic [DATA_W-1:0] WIPER_INIT = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_nvm,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NW*DATA_W-1:0] wipers,
    output logic [NN*DATA_W-1:0] nvm
);
    for (genvar i = 0; i < NW; i++) begin : g_wiper
        always_ff @(posedge clk) begin
            if (rst)
                wipers[i*DATA_W +: DATA_W] <= WIPER_INIT;
            else if (wr_en && !wr_nvm && wr_addr == REG_AW'(i))
                wipers[i*DATA_W +: DATA_W] <= wr_data;
        end
    end

    for (genvar j = 0; j < NN; j++) begin : g_nvm
        always_ff @(posedge clk) begin
            if (rst)
                nvm[j*DATA_W +: DATA_W] <= '0;
            else if (wr_en && wr_nvm && wr_addr == REG_AW'(j))
                nvm[j*DATA_W +: DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/potctl_i2c_slave.sv
module potctl_i2c_slave
    import potctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_drive_low,
    input  logic [1:0]                strap_addr,
    output logic                      cmd_strobe,
    output logic [CODE_W-1:0]         cmd_code,
    output logic [1:0]                cmd_wiper,
    output logic [N_WIPER*DATA_W-1:0] wiper_q,
    output logic [N_NVM*DATA_W-1:0]   nvm_q
);
    localparam int IDX_W = $clog2(N_WIPER);
    localparam logic [BITCNT_W-1:0] ACK_POS = BITCNT_W'(DATA_W);

    logic scl_s, scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic [BITCNT_W-1:0] bitcnt;
    logic [DATA_W-1:0]   rx_byte;
    logic byte_rx, ack_slot, ack_bit;

    phase_t            st;
    logic              in_idle;
    logic              drv;
    logic              ack_pend;
    logic              tx_on;
    logic              rd_first;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] tx_sr;
    logic              wr_en, wr_nvm;
    logic [REG_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    cmd_view_t         cmd_v;
    reg_view_t         reg_v;
    logic [2:0]        tx_pos;

    potctl_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    potctl_bit_shift u_shift (
        .clk(clk), .rst(rst), .clr(start_det | stop_det),
        .rise(scl_rise), .sda(sda_s), .bitcnt(bitcnt),
        .rx_byte(rx_byte), .byte_rx(byte_rx),
        .ack_slot(ack_slot), .ack_bit(ack_bit)
    );

    potctl_regbank u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_nvm(wr_nvm),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .wipers(wiper_q), .nvm(nvm_q)
    );

    assign cmd_v   = cmd_view_t'(rx_byte);
    assign reg_v   = reg_view_t'(rx_byte);
    assign in_idle = (st == ST_IDLE);
    assign tx_pos  = 3'(DATA_W - 1) - bitcnt[2:0];
    assign sda_drive_low = drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            drv        <= 1'b0;
            ack_pend   <= 1'b0;
            tx_on      <= 1'b0;
            rd_first   <= 1'b0;
            rd_idx     <= '0;
            tx_sr      <= '0;
            wr_en      <= 1'b0;
            wr_nvm     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            cmd_strobe <= 1'b0;
            cmd_code   <= '0;
            cmd_wiper  <= '0;
        end else begin
            cmd_strobe <= 1'b0;
            wr_en      <= 1'b0;
            if (start_det) begin
                st       <= ST_ADDR;
                drv      <= 1'b0;
                ack_pend <= 1'b0;
                tx_on    <= 1'b0;
            end else if (stop_det) begin
                st       <= ST_IDLE;
                drv      <= 1'b0;
                ack_pend <= 1'b0;
                tx_on    <= 1'b0;
            end else begin
                if (byte_rx) begin
                    unique case (st)
                        ST_ADDR: begin
                            if (!dev_match(rx_byte, strap_addr)) begin
                                st <= ST_IDLE;
                            end else if (rx_byte[0]) begin
                                st       <= ST_READ;
                                ack_pend <= 1'b1;
                                tx_on    <= 1'b1;
                                rd_first <= 1'b1;
                                rd_idx   <= '0;
                                tx_sr    <= wiper_q[DATA_W-1:0];
                            end else begin
                                st       <= ST_INSTR;
                                ack_pend <= 1'b1;
                            end
                        end
                        ST_INSTR: begin
                            ack_pend <= 1'b1;
                            if (cmd_v.is_cmd) begin
                                st <= ST_DONE;
                                if (sel_valid(cmd_v.sel)) begin
                                    cmd_strobe <= 1'b1;
                                    cmd_code   <= cmd_v.code;
                                    cmd_wiper  <= cmd_v.sel[1:0];
                                end
                            end else begin
                                st      <= ST_DATA;
                                wr_nvm  <= reg_v.to_nvm;
                                wr_addr <= reg_v.addr;
                            end
                        end
                        ST_DATA: begin
                            ack_pend <= 1'b1;
                            wr_en    <= 1'b1;
                            wr_data  <= rx_byte;
                            st       <= ST_DONE;
                        end
                        ST_DONE: ack_pend <= 1'b1;
                        default: ;
                    endcase
                end
                if (ack_slot) begin
                    ack_pend <= 1'b0;
                    if (st == ST_READ) begin
                        if (rd_first) begin
                            rd_first <= 1'b0;
                        end else if (!ack_bit) begin
                            rd_idx <= rd_idx + 1'b1;
                            tx_sr  <= wiper_q[(IDX_W'(rd_idx + 1'b1))*DATA_W +: DATA_W];
                        end else begin
                            st    <= ST_IDLE;
                            tx_on <= 1'b0;
                        end
                    end
                end
                if (scl_fall) begin
                    if (bitcnt == ACK_POS)
                        drv <= ack_pend;
                    else if (tx_on)
                        drv <= ~tx_sr[tx_pos];
                    else
                        drv <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/potctl_i2c_chk.sv
module potctl_i2c_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       drive,
    input logic       cmd_strobe,
    input logic [1:0] cmd_wiper,
    input logic       in_idle
);
    // R12
    drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(drive));

    // R7
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    // R8
    strobe_wiper_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> cmd_wiper[0]);

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> !drive);

    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !drive);
endmodule

bind potctl_i2c_slave potctl_i2c_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .drive(sda_drive_low), .cmd_strobe(cmd_strobe),
    .cmd_wiper(cmd_wiper), .in_idle(in_idle)
);

// File: tb/potctl_i2c_slave_tb.sv
module potctl_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_drive_low, cmd_strobe;
    logic [3:0] cmd_code;
    logic [1:0] cmd_wiper;
    logic [31:0] wiper_q;
    logic [127:0] nvm_q;
    logic sda_line;
    int errors = 0, checks = 0;

    typedef struct packed { logic [3:0] code; logic [1:0] wip; } strobe_t;
    strobe_t exp_q[$];

    assign sda_line = sda_m & ~sda_drive_low;
    always #(CLK_PERIOD/2) clk = ~clk;

    potctl_i2c_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low), .strap_addr(strap),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_wiper(cmd_wiper),
        .wiper_q(wiper_q), .nvm_q(nvm_q)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for command strobes
    always @(negedge clk) begin
        if (!rst && cmd_strobe) begin
            strobe_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected strobe actual=%0h expected=none", {cmd_code, cmd_wiper});
            end else begin
                e = exp_q.pop_front();
                if ({cmd_code, cmd_wiper} != e) begin
                    errors++;
                    $display("FAIL R7 strobe actual=%0h expected=%0h", {cmd_code, cmd_wiper}, e);
                end
            end
        end
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack_n);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(nack);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] s, input logic rd);
        return {5'b01011, s, rd};
    endfunction

    task automatic reg_write(input logic [7:0] instr, input logic [7:0] data, input string tag);
        logic a;
        bus_start;
        send_byte(dev(strap, 1'b0), a); check(a == 1'b0, tag, a, 0);
        send_byte(instr, a);            check(a == 1'b0, tag, a, 0);
        send_byte(data, a);             check(a == 1'b0, tag, a, 0);
        bus_stop;
    endtask

    task automatic command(input logic [3:0] code, input logic [2:0] sel, input string tag);
        logic a;
        if (sel == 3'b001 || sel == 3'b011) exp_q.push_back({code, sel[1:0]});
        bus_start;
        send_byte(dev(strap, 1'b0), a); check(a == 1'b0, tag, a, 0);
        send_byte({1'b1, code, sel}, a); check(a == 1'b0, tag, a, 0);
        bus_stop;
        wq(4);
    endtask

    function automatic logic [7:0] wip(input int i); return wiper_q[i*8 +: 8]; endfunction

    initial begin
        logic a;
        logic [7:0] v;
        logic [31:0] wsave;
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=running expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        repeat (5) @(posedge clk);
        rst = 1'b0;
        wq(4);
        // R11 reset state
        check(wiper_q == {4{8'h80}}, "R11 wipers", wiper_q, 32'h80808080);
        check(nvm_q == '0, "R11 nvm", int'(nvm_q[31:0]), 0);
        check(sda_drive_low == 1'b0 && cmd_strobe == 1'b0, "R11 lines", sda_drive_low, 0);

        // R1 / R4: wiper write
        reg_write(8'h02, 8'h3C, "R1 R4 acks");
        check(wip(2) == 8'h3C, "R4 wiper2", wip(2), 8'h3C);

        // R2: foreign address, then bytes that would otherwise write
        wsave = wiper_q;
        bus_start;
        send_byte(dev(2'b01, 1'b0), a); check(a == 1'b1, "R2 no ack", a, 1);
        send_byte(8'h00, a);            check(a == 1'b1, "R2 ignored", a, 1);
        send_byte(8'h55, a);
        bus_stop;
        check(wiper_q == wsave, "R2 no write", wiper_q, wsave);

        // R5 nvm write
        reg_write(8'h25, 8'hA5, "R5 acks");
        check(nvm_q[5*8 +: 8] == 8'hA5, "R5 nvm5", nvm_q[5*8 +: 8], 8'hA5);

        // R6 unimplemented addresses
        wsave = wiper_q;
        reg_write(8'h09, 8'h77, "R6 acks");
        check(wiper_q == wsave, "R6 wiper addr9", wiper_q, wsave);
        reg_write(8'h34, 8'h77, "R6 acks nvm");
        check(nvm_q[127:0] == {80'h0, 8'hA5, 40'h0}, "R6 nvm addr20", int'(nvm_q[47:40]), 8'hA5);

        // R7 valid commands, R8 invalid
        command(4'hB, 3'b001, "R7 cmd1");
        command(4'h5, 3'b011, "R7 cmd3");
        command(4'h3, 3'b010, "R8 bad sel");
        command(4'h9, 3'b000, "R8 bad sel0");
        check(exp_q.size() == 0, "R7 all strobes seen", exp_q.size(), 0);

        // R3: aborted byte followed by repeated start, no stop before it
        bus_start;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start;
        send_byte(dev(strap, 1'b0), a); check(a == 1'b0, "R3 restart ack", a, 0);
        send_byte(8'h00, a);
        send_byte(8'h11, a);
        bus_start;
        send_byte(dev(strap, 1'b0), a); check(a == 1'b0, "R3 repeated start", a, 0);
        send_byte(8'h01, a);
        send_byte(8'h22, a);
        bus_stop;
        check(wip(0) == 8'h11 && wip(1) == 8'h22, "R3 writes", {wip(1), wip(0)}, 16'h2211);
        check(sda_drive_low == 1'b0, "R3 released", sda_drive_low, 0);
        reg_write(8'h03, 8'h44, "R4 acks w3");

        // R9 read with wrap
        bus_start;
        send_byte(dev(strap, 1'b1), a); check(a == 1'b0, "R9 read ack", a, 0);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] e;
            e = (i % 4 == 0) ? 8'h11 : (i % 4 == 1) ? 8'h22 : (i % 4 == 2) ? 8'h3C : 8'h44;
            recv_byte(v, (i == 4));
            check(v == e, "R9 read byte", v, e);
        end
        bus_stop;
        // R10 nack end and restart at wiper 0
        check(sda_drive_low == 1'b0, "R10 released", sda_drive_low, 0);
        bus_start;
        send_byte(dev(strap, 1'b1), a);
        recv_byte(v, 1'b0); check(v == 8'h11, "R10 first", v, 8'h11);
        recv_byte(v, 1'b1); check(v == 8'h22, "R10 second", v, 8'h22);
        check(sda_drive_low == 1'b0, "R10 release after nack", sda_drive_low, 0);
        bus_stop;
        bus_start;
        send_byte(dev(strap, 1'b1), a);
        recv_byte(v, 1'b1); check(v == 8'h11, "R10 restart at w0", v, 8'h11);
        bus_stop;

        // R1 with another strap value
        strap = 2'b01;
        wq(4);
        bus_start;
        send_byte(dev(2'b10, 1'b0), a); check(a == 1'b1, "R1 old strap", a, 1);
        bus_stop;
        reg_write(8'h00, 8'h5E, "R1 new strap");
        check(wip(0) == 8'h5E, "R1 write via new strap", wip(0), 8'h5E);
        // R12: line released while idle
        check(sda_drive_low == 1'b0, "R12 idle", sda_drive_low, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule